// File: doc/BRIEF.md
# SPDIF receiver lock status tracker

This block follows whether an SPDIF receiver has locked onto its input stream. It also keeps the small set of sticky status flags and interrupt enables that software reads. The front end reports decoded events to it as single-cycle pulses:
- one pulse for every subframe decoded cleanly;
- one pulse for every unexpected bi-phase error;
- one pulse each time a full block of user and channel-status bits has been gathered.

The lock decision uses a run of clean subframes. Any bi-phase error restarts the run, or drops lock if lock was held.

The live lock state is exclusive: the receiver is either locked or unlocked, never both. Entering each state sets its own sticky flag, and software clears a flag by writing a one to it. Any sticky flag can be enabled to drive a registered interrupt line. The capture-enable input does not affect lock tracking. It is only combined with the live lock state to give a capture-go output for the downstream capture path.

Top module: `spdif_lock_tracker`

## Requirements
- R1: After reset, `locked`, `stickyLock`, `stickyUc`, `irq` and every interrupt enable are 0, and `stickyUnlock` is 1.
- R2: While unlocked, the receiver locks on the clock edge that samples the third `subframeValid` pulse of a run with no `biphaseErr` in between. Idle cycles do not break the run, and `stickyLock` is set on that same edge.
- R3: A `biphaseErr` pulse while locked clears `locked` and sets `stickyUnlock` on the same edge. A `biphaseErr` pulse while unlocked only restarts the run and sets no flag.
- R4: A write with `wrAddr`=0 clears each sticky flag whose `wrData` bit is 1 (bit 0 LOCK, bit 1 UNLOCK, bit 2 UCBITS). Flags whose bit is 0 keep their value, and flags stay set until cleared this way.
- R5: If a clear of a flag and a set event for that flag fall on the same edge, the flag ends up set.
- R6: A `blockDone` pulse sets `stickyUc` on the edge that samples it.
- R7: A write with `wrAddr`=1 loads the interrupt enables, with the same bit layout as R4. `irq` is a register that goes high one edge after any enabled flag is set, and goes low one edge after no enabled flag is set.
- R8: `captureEn` has no effect on the lock state or on any flag. `captureGo` equals `captureEn` AND `locked` combinationally.
- R9: When `biphaseErr` and `subframeValid` arrive in the same cycle, the error takes effect and the subframe is not counted.
- R10: While locked, further `subframeValid` pulses leave `locked` at 1 and do not set `stickyLock` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| subframeValid | input | 1 | Pulse: a subframe was decoded without error |
| biphaseErr | input | 1 | Pulse: unexpected bi-phase error |
| captureEn | input | 1 | Capture enable from software |
| blockDone | input | 1 | Pulse: full block of user/channel-status bits collected |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 1 | 0 = flag clear register, 1 = interrupt enable register |
| wrData | input | 3 | Write data, bit 0 LOCK, bit 1 UNLOCK, bit 2 UCBITS |
| locked | output | 1 | Live lock state |
| captureGo | output | 1 | Capture enabled and locked |
| stickyLock | output | 1 | Sticky LOCK flag |
| stickyUnlock | output | 1 | Sticky UNLOCK flag |
| stickyUc | output | 1 | Sticky UCBITS flag |
| irq | output | 1 | Registered interrupt |

## Verification
Two pairs of functions can coincide on one edge.

The first pair is a software clear and a hardware set of the same flag. The bench provokes it by writing a clear to UNLOCK in the very cycle a bi-phase error drops lock, and a clear to UCBITS alongside a `blockDone` pulse. The flag must read back set afterwards.

The second pair is a bi-phase error arriving together with a clean-subframe pulse. The bench checks that the run restarts, so that three further clean pulses are still needed before lock.

A reference model in the bench predicts every cycle's outputs, and a scoreboard compares them.

// File: rtl/spdif_lock_pkg.sv
package spdif_lock_pkg;
  localparam int NFLAGS = 3;
  localparam int FLAG_LOCK = 0;
  localparam int FLAG_UNLOCK = 1;
  localparam int FLAG_UC = 2;
  localparam logic [NFLAGS-1:0] FLAG_RESET = 3'b010;

  typedef struct packed {
    logic setUc;
    logic setUnlock;
    logic setLock;
  } strobeT;
endpackage

// File: rtl/spdif_lock_ctrl.sv
module spdif_lock_ctrl
  import spdif_lock_pkg::*;
#(
  parameter int LOCK_RUN = 3
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   subframeValid,
  input  logic   biphaseErr,
  input  logic   blockDone,
  output logic   locked,
  output strobeT strobe
);
  localparam int CNT_W = $clog2(LOCK_RUN + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LOCK_RUN - 1);

  typedef enum logic {ST_UNLOCKED = 1'b0, ST_LOCKED = 1'b1} stateT;

  stateT state, stateNext;
  logic [CNT_W-1:0] runCnt, runCntNext;

  always_comb begin
    stateNext  = state;
    runCntNext = runCnt;
    strobe     = '0;
    strobe.setUc = blockDone;
    if (biphaseErr) begin
      runCntNext = '0;
      if (state == ST_LOCKED) begin
        stateNext = ST_UNLOCKED;
        strobe.setUnlock = 1'b1;
      end
    end else if (subframeValid && state == ST_UNLOCKED) begin
      if (runCnt == LAST) begin
        stateNext  = ST_LOCKED;
        runCntNext = '0;
        strobe.setLock = 1'b1;
      end else begin
        runCntNext = runCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_UNLOCKED;
      runCnt <= '0;
    end else begin
      state  <= stateNext;
      runCnt <= runCntNext;
    end
  end

  assign locked = (state == ST_LOCKED);
endmodule

// File: rtl/spdif_lock_regs.sv
module spdif_lock_regs
  import spdif_lock_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobe,
  input  logic              wrEn,
  input  logic              wrAddr,
  input  logic [NFLAGS-1:0] wrData,
  output logic [NFLAGS-1:0] flags,
  output logic              irq
);
  logic [NFLAGS-1:0] setVec;
  logic [NFLAGS-1:0] clrVec;
  logic [NFLAGS-1:0] enables;

  assign setVec = {strobe.setUc, strobe.setUnlock, strobe.setLock};
  assign clrVec = (wrEn && !wrAddr) ? wrData : '0;

  for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) flags[i] <= FLAG_RESET[i];
      else       flags[i] <= (flags[i] & ~clrVec[i]) | setVec[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enables <= '0;
      irq     <= 1'b0;
    end else begin
      if (wrEn && wrAddr) enables <= wrData;
      irq <= |(flags & enables);
    end
  end
endmodule

// File: rtl/spdif_lock_tracker.sv
module spdif_lock_tracker
  import spdif_lock_pkg::*;
#(
  parameter int LOCK_RUN = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       subframeValid,
  input  logic       biphaseErr,
  input  logic       captureEn,
  input  logic       blockDone,
  input  logic       wrEn,
  input  logic       wrAddr,
  input  logic [2:0] wrData,
  output logic       locked,
  output logic       captureGo,
  output logic       stickyLock,
  output logic       stickyUnlock,
  output logic       stickyUc,
  output logic       irq
);
  strobeT strobe;
  logic [NFLAGS-1:0] flags;

  spdif_lock_ctrl #(.LOCK_RUN(LOCK_RUN)) u_ctrl (
    .clk(clk), .rstN(rstN), .subframeValid(subframeValid),
    .biphaseErr(biphaseErr), .blockDone(blockDone),
    .locked(locked), .strobe(strobe)
  );

  spdif_lock_regs u_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .flags(flags), .irq(irq)
  );

  assign stickyLock   = flags[FLAG_LOCK];
  assign stickyUnlock = flags[FLAG_UNLOCK];
  assign stickyUc     = flags[FLAG_UC];
  assign captureGo    = captureEn & locked;
endmodule

// File: rtl/spdif_lock_checker.sv
module spdif_lock_checker (
  input logic       clk,
  input logic       rstN,
  input logic       subframeValid,
  input logic       biphaseErr,
  input logic       blockDone,
  input logic       wrEn,
  input logic       wrAddr,
  input logic [2:0] wrData,
  input logic       locked,
  input logic       stickyLock,
  input logic       stickyUnlock,
  input logic       stickyUc,
  input logic       irq
);
  p_lock_sets_flag_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> stickyLock);

  p_lock_needs_clean_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> ($past(subframeValid) && !$past(biphaseErr)));

  p_err_drops_lock_r3: assert property (@(posedge clk) disable iff (!rstN)
    (locked && biphaseErr) |=> (!locked && stickyUnlock));

  p_lock_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stickyLock && !(wrEn && !wrAddr && wrData[0])) |=> stickyLock);

  p_block_sets_uc_r6: assert property (@(posedge clk) disable iff (!rstN)
    blockDone |=> stickyUc);

  p_irq_has_source_r7: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> $past(stickyLock || stickyUnlock || stickyUc));

  p_locked_stays_r10: assert property (@(posedge clk) disable iff (!rstN)
    (locked && !biphaseErr) |=> locked);
endmodule

bind spdif_lock_tracker spdif_lock_checker u_checker (
  .clk(clk), .rstN(rstN), .subframeValid(subframeValid),
  .biphaseErr(biphaseErr), .blockDone(blockDone), .wrEn(wrEn),
  .wrAddr(wrAddr), .wrData(wrData), .locked(locked),
  .stickyLock(stickyLock), .stickyUnlock(stickyUnlock),
  .stickyUc(stickyUc), .irq(irq)
);

// File: tb/spdif_lock_tracker_tb.sv
module spdif_lock_tracker_tb;
  localparam int PERIOD = 10;
  localparam int RUN = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic subframeValid = 1'b0, biphaseErr = 1'b0, captureEn = 1'b0;
  logic blockDone = 1'b0, wrEn = 1'b0, wrAddr = 1'b0;
  logic [2:0] wrData = '0;
  logic locked, captureGo, stickyLock, stickyUnlock, stickyUc, irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // expected vector: {locked, stickyUc, stickyUnlock, stickyLock, irq, captureGo}
  logic [5:0] expQ[$];
  string tagQ[$];

  // reference model state
  logic mLocked = 1'b0;
  int mCnt = 0;
  logic [2:0] mFlags = 3'b010;
  logic [2:0] mEn = 3'b000;
  logic mIrq = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  spdif_lock_tracker u_dut (
    .clk(clk), .rstN(rstN), .subframeValid(subframeValid),
    .biphaseErr(biphaseErr), .captureEn(captureEn), .blockDone(blockDone),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .locked(locked),
    .captureGo(captureGo), .stickyLock(stickyLock),
    .stickyUnlock(stickyUnlock), .stickyUc(stickyUc), .irq(irq)
  );

  function automatic logic [5:0] actual();
    return {locked, stickyUc, stickyUnlock, stickyLock, irq, captureGo};
  endfunction

  task automatic compare(input logic [5:0] exp, input string tag);
    checks++;
    if (actual() !== exp) begin
      fails++;
      $display("FAIL %s: {locked,uc,unlock,lock,irq,go} actual %b expected %b",
               tag, actual(), exp);
    end
  endtask

  // driver: applies one cycle of stimulus and pushes the predicted outputs
  task automatic step(input logic sub, input logic err, input logic blk,
                      input logic cap, input logic wr, input logic adr,
                      input logic [2:0] dat, input string tag);
    logic [2:0] clr;
    logic [2:0] setv;
    logic irqNext;
    @(negedge clk);
    subframeValid = sub; biphaseErr = err; blockDone = blk;
    captureEn = cap; wrEn = wr; wrAddr = adr; wrData = dat;
    irqNext = |(mFlags & mEn);
    clr = (wr && !adr) ? dat : 3'b000;
    setv = {blk, 2'b00};
    if (err) begin
      mCnt = 0;
      if (mLocked) begin
        mLocked = 1'b0;
        setv[1] = 1'b1;
      end
    end else if (sub && !mLocked) begin
      if (mCnt == RUN - 1) begin
        mLocked = 1'b1;
        mCnt = 0;
        setv[0] = 1'b1;
      end else begin
        mCnt++;
      end
    end
    mFlags = (mFlags & ~clr) | setv;
    if (wr && adr) mEn = dat;
    mIrq = irqNext;
    expQ.push_back({mLocked, mFlags[2], mFlags[1], mFlags[0], mIrq, cap & mLocked});
    tagQ.push_back(tag);
  endtask

  task automatic idle(input int n, input logic cap, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, cap, 0, 0, 3'b000, tag);
  endtask

  // monitor: pops the prediction for the edge just taken
  initial begin
    forever begin
      @(posedge clk);
      #(PERIOD/4);
      if (expQ.size() > 0) compare(expQ.pop_front(), tagQ.pop_front());
    end
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    compare(6'b001000, "R1 reset state");

    // R1: enables start at zero, so UNLOCK set raises no irq
    idle(2, 0, "R1 no irq after reset");

    // R2: run with idle gaps
    step(1, 0, 0, 0, 0, 0, 3'b000, "R2 first clean subframe");
    idle(1, 0, "R2 idle keeps run");
    step(1, 0, 0, 0, 0, 0, 3'b000, "R2 second clean subframe");
    // R2: error restarts run while unlocked (R3: no flag set)
    step(0, 1, 0, 0, 0, 0, 3'b000, "R3 error while unlocked");
    step(1, 0, 0, 0, 0, 0, 3'b000, "R2 run restart 1");
    step(1, 0, 0, 0, 0, 0, 3'b000, "R2 run restart 2");
    step(1, 0, 0, 0, 0, 0, 3'b000, "R2 lock on third");
    // R10: further subframes while locked
    step(0, 0, 0, 0, 1, 0, 3'b001, "R4 clear LOCK");
    step(1, 0, 0, 0, 0, 0, 3'b000, "R10 subframe while locked");
    step(1, 0, 0, 0, 0, 0, 3'b000, "R10 subframe while locked");

    // R4: zero bits have no effect, then clear UNLOCK
    step(0, 0, 0, 0, 1, 0, 3'b000, "R4 zero-bit write");
    step(0, 0, 0, 0, 1, 0, 3'b010, "R4 clear UNLOCK");
    idle(1, 0, "R4 cleared flags stay cleared");

    // R8: capture enable only gates captureGo
    step(0, 0, 0, 1, 0, 0, 3'b000, "R8 captureGo while locked");
    idle(2, 1, "R8 captureEn steady");

    // R7: enable UNLOCK and UCBITS
    step(0, 0, 0, 1, 1, 1, 3'b110, "R7 write enables");
    step(0, 0, 1, 1, 0, 0, 3'b000, "R6 blockDone sets UCBITS");
    idle(2, 1, "R7 irq follows one edge later");
    step(0, 0, 0, 1, 1, 0, 3'b100, "R7 clear UCBITS");
    idle(2, 1, "R7 irq drops");

    // R5: drop lock while clearing UNLOCK in the same cycle
    step(0, 1, 0, 1, 1, 0, 3'b010, "R5 clear vs unlock set");
    idle(2, 1, "R5 UNLOCK kept, irq up");
    step(0, 0, 1, 1, 1, 0, 3'b100, "R5 clear vs UCBITS set");
    idle(1, 1, "R5 UCBITS kept");
    step(0, 0, 0, 1, 1, 0, 3'b110, "R4 clear both");
    idle(2, 1, "R7 irq low again");

    // R9: error and subframe together, captureEn low during relock (R8)
    step(1, 0, 0, 0, 0, 0, 3'b000, "R9 clean 1");
    step(1, 0, 0, 0, 0, 0, 3'b000, "R9 clean 2");
    step(1, 1, 0, 0, 0, 0, 3'b000, "R9 error wins over subframe");
    step(1, 0, 0, 0, 0, 0, 3'b000, "R9 restart 1");
    step(1, 0, 0, 0, 0, 0, 3'b000, "R9 restart 2");
    step(1, 0, 0, 0, 0, 0, 3'b000, "R8 lock with capture off");
    step(0, 0, 0, 1, 1, 1, 3'b001, "R7 enable LOCK only");
    idle(2, 1, "R7 LOCK raises irq");
    step(0, 1, 0, 1, 0, 0, 3'b000, "R3 error while locked");
    idle(2, 0, "R3 unlocked stays");

    @(posedge clk);
    #(PERIOD/2);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule